// File: doc/BRIEF.md
# Scatter-Gather DMA Task Sequencer

This block walks a chain of copy tasks kept in memory. Software programs one loader descriptor (the primary) with the end address of a task list and a word count. A single pulse on `start` then runs the whole chain without further requests. In each loader phase the block reads up to four consecutive list words into its internal task slot (the alternate). The first three words fill the slot's source end pointer, destination end pointer and control word. The fourth word is read and thrown away. The block then runs the word copy that the slot describes. What happens next depends on the task's code: it either returns to the loader for the next four words or ends the chain.

A chain that ends on a basic task raises `done` for one cycle. A chain that ends on an invalid descriptor raises a sticky `err` instead. `err` stays high until software writes either primary field. Memory is reached through a word-wide request channel with valid/ready handshaking. Read data comes back on a separate response strobe. The block keeps at most one read outstanding, and it takes the response whenever the strobe arrives.

Top module: `sg_chain_dma`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `mem_req_valid` are all low.
- R2: A single `start` pulse while idle runs the entire chain with no further requests. `busy` stays high from the cycle after `start` until the chain ends.
- R3: The primary is valid only if its control word has code 3'b100 in bits [2:0] and arbitration value 4'b0010 in bits [17:14]. A valid primary reads list words one at a time, stopping after four or when its count runs out. The words come in ascending address order. Words 0, 1 and 2 load the slot's source end, destination end and control. No memory write is issued during a loader phase.
- R4: A control word holds the number of words minus one in bits [13:4]. With that value n, word i of a transfer sits at end pointer − n + i. This applies to the task list and to both sides of a task.
- R5: A running task reads n+1 source words and writes each one to its destination before it reads the next. The data matches word for word.
- R6: A task with code 3'b101 returns to the loader once its copy finishes. A task with code 3'b001 ends the chain after its copy. `done` is high for exactly one cycle at that point, with `busy` already low, and is never raised at the end of an intermediate task.
- R7: Some descriptors are invalid. For the primary, that is any code other than 3'b100 or any arbitration value other than 4'b0010. For a loaded task, that is any code other than 3'b001 or 3'b101. An invalid descriptor ends the chain with `err` set and `done` low. An invalid primary issues no memory request, and a rejected task issues no copy access.
- R8: Once a loader phase consumes the last list word, the primary's code becomes 3'b000. A later `start` without reprogramming therefore ends at once with `err` set and no memory request.
- R9: `err` stays set until a write to the configuration port, which clears it.
- R10: Each memory request is accepted in a cycle where both `mem_req_valid` and `mem_req_ready` are high. While `mem_req_ready` is low, the address, write flag and write data hold steady. No new request is issued while a read response is outstanding.
- R11: A configuration write with `cfg_sel` = 0 loads the primary source end pointer from the low address bits. With `cfg_sel` = 1 it loads the whole primary control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Chain start pulse, taken while idle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: primary source end, 1: primary control |
| cfg_wdata | input | 32 | Configuration write data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted when high with valid |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_addr | output | AW | Word address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_rdata | input | 32 | Read data |
| busy | output | 1 | Chain in progress |
| done | output | 1 | One-cycle pulse at the end of a chain that finishes on a basic task |
| err | output | 1 | Sticky invalid-descriptor flag |

## Verification
The bench targets three kinds of chain ending. One ends on a basic task, one runs off the end of the list after a task that hands back to the loader, and one ends on a loaded task coded invalid. A design that pulsed `done` after each task, or after an error, would show the wrong done count. A design that failed to invalidate the primary would loop through stale list words rather than stop. The bench runs a one-word task and tasks of several lengths, which catches an end-pointer offset that is off by one: such a design writes outside the cleared destination window or misses its first word. Back-pressure patterns of several stall lengths expose a request that changes while it is stalled. A bad arbitration field, a re-start after exhaustion and the clearing of `err` by a configuration write are each driven directly.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 10;
  localparam int CNT_LO = 4;
  localparam int ARB_LO = 14;
  localparam int ARB_W  = 4;

  localparam logic [2:0] CC_INVALID = 3'b000;
  localparam logic [2:0] CC_BASIC   = 3'b001;
  localparam logic [2:0] CC_SG_PRI  = 3'b100;
  localparam logic [2:0] CC_SG_ALT  = 3'b101;
  localparam logic [ARB_W-1:0] ARB_FOUR = 4'b0010;
  localparam int LOAD_BEATS = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PCHK, ST_PRD, ST_PWT, ST_ACHK, ST_ARD, ST_AWT, ST_AWR
  } seq_st_e;

  function automatic logic [2:0] cw_code(logic [WORD_W-1:0] c);
    return c[2:0];
  endfunction

  function automatic logic [CNT_W-1:0] cw_cnt(logic [WORD_W-1:0] c);
    return c[CNT_LO +: CNT_W];
  endfunction

  function automatic logic [ARB_W-1:0] cw_arb(logic [WORD_W-1:0] c);
    return c[ARB_LO +: ARB_W];
  endfunction

  function automatic logic [WORD_W-1:0] cw_update(logic [WORD_W-1:0] c,
                                                  logic [CNT_W-1:0] n,
                                                  logic [2:0] code);
    logic [WORD_W-1:0] r;
    r = c;
    r[CNT_LO +: CNT_W] = n;
    r[2:0] = code;
    return r;
  endfunction
endpackage

// File: rtl/sg_desc_store.sv
module sg_desc_store
  import sg_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic              sw_sel,
  input  logic [WORD_W-1:0] sw_wdata,
  input  logic              ld_we,
  input  logic [1:0]        ld_idx,
  input  logic [WORD_W-1:0] ld_data,
  input  logic              pc_we,
  input  logic [WORD_W-1:0] pc_data,
  output logic [AW-1:0]     pri_src,
  output logic [WORD_W-1:0] pri_ctrl,
  output logic [AW-1:0]     alt_src,
  output logic [AW-1:0]     alt_dst,
  output logic [WORD_W-1:0] alt_ctrl
);
  localparam int SLOT_N = 3;

  logic [WORD_W-1:0] slot_q [SLOT_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_src  <= '0;
      pri_ctrl <= '0;
    end else begin
      if (sw_we && !sw_sel) pri_src <= sw_wdata[AW-1:0];
      if (pc_we) pri_ctrl <= pc_data;
      else if (sw_we && sw_sel) pri_ctrl <= sw_wdata;
    end
  end

  for (genvar g = 0; g < SLOT_N; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[g] <= '0;
      else if (ld_we && ld_idx == 2'(g)) slot_q[g] <= ld_data;
    end
  end

  assign alt_src  = slot_q[0][AW-1:0];
  assign alt_dst  = slot_q[1][AW-1:0];
  assign alt_ctrl = slot_q[2];

  logic unused_slot_hi;
  assign unused_slot_hi = ^{slot_q[0], slot_q[1]};
endmodule

// File: rtl/sg_seq.sv
module sg_seq
  import sg_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cfg_we,
  input  logic [AW-1:0]     pri_src,
  input  logic [WORD_W-1:0] pri_ctrl,
  input  logic [AW-1:0]     alt_src,
  input  logic [AW-1:0]     alt_dst,
  input  logic [WORD_W-1:0] alt_ctrl,
  output logic              ld_we,
  output logic [1:0]        ld_idx,
  output logic [WORD_W-1:0] ld_data,
  output logic              pc_we,
  output logic [WORD_W-1:0] pc_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [AW-1:0]     mem_req_addr,
  output logic [WORD_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_rdata,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam logic [1:0] LAST_BEAT = 2'(LOAD_BEATS - 1);

  seq_st_e           st_q;
  logic [1:0]        beat_q;
  logic [CNT_W-1:0]  pn_q, an_q;
  logic [WORD_W-1:0] buf_q;
  logic              chain_q, done_q, err_q;
  logic              phase_last, pri_ok, alt_ok;
  logic [CNT_W-1:0]  pn_next;

  assign pri_ok     = (cw_code(pri_ctrl) == CC_SG_PRI) && (cw_arb(pri_ctrl) == ARB_FOUR);
  assign alt_ok     = (cw_code(alt_ctrl) == CC_BASIC) || (cw_code(alt_ctrl) == CC_SG_ALT);
  assign phase_last = (pn_q == '0) || (beat_q == LAST_BEAT);
  assign pn_next    = (pn_q == '0) ? '0 : pn_q - CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      beat_q  <= '0;
      pn_q    <= '0;
      an_q    <= '0;
      buf_q   <= '0;
      chain_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (cfg_we) err_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (start) st_q <= ST_PCHK;
        ST_PCHK: begin
          if (pri_ok) begin
            pn_q   <= cw_cnt(pri_ctrl);
            beat_q <= '0;
            st_q   <= ST_PRD;
          end else begin
            err_q <= 1'b1;
            st_q  <= ST_IDLE;
          end
        end
        ST_PRD: if (mem_req_ready) st_q <= ST_PWT;
        ST_PWT: begin
          if (mem_rsp_valid) begin
            beat_q <= beat_q + 2'd1;
            pn_q   <= pn_next;
            st_q   <= phase_last ? ST_ACHK : ST_PRD;
          end
        end
        ST_ACHK: begin
          if (alt_ok) begin
            an_q    <= cw_cnt(alt_ctrl);
            chain_q <= (cw_code(alt_ctrl) == CC_SG_ALT);
            st_q    <= ST_ARD;
          end else begin
            err_q <= 1'b1;
            st_q  <= ST_IDLE;
          end
        end
        ST_ARD: if (mem_req_ready) st_q <= ST_AWT;
        ST_AWT: begin
          if (mem_rsp_valid) begin
            buf_q <= mem_rsp_rdata;
            st_q  <= ST_AWR;
          end
        end
        ST_AWR: begin
          if (mem_req_ready) begin
            if (an_q != '0) begin
              an_q <= an_q - CNT_W'(1);
              st_q <= ST_ARD;
            end else if (chain_q) begin
              st_q <= ST_PCHK;
            end else begin
              done_q <= 1'b1;
              st_q   <= ST_IDLE;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ld_we   = (st_q == ST_PWT) && mem_rsp_valid && (beat_q != LAST_BEAT);
  assign ld_idx  = beat_q;
  assign ld_data = mem_rsp_rdata;
  assign pc_we   = (st_q == ST_PWT) && mem_rsp_valid && phase_last;
  assign pc_data = cw_update(pri_ctrl, pn_next,
                             (pn_q == '0) ? CC_INVALID : CC_SG_PRI);

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_we    = 1'b0;
    mem_req_addr  = '0;
    case (st_q)
      ST_PRD: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = pri_src - AW'(pn_q);
      end
      ST_ARD: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = alt_src - AW'(an_q);
      end
      ST_AWR: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        mem_req_addr  = alt_dst - AW'(an_q);
      end
      default: ;
    endcase
  end

  assign mem_req_wdata = buf_q;
  assign busy = (st_q != ST_IDLE);
  assign done = done_q;
  assign err  = err_q;
endmodule

// File: rtl/sg_chain_dma.sv
module sg_chain_dma
  import sg_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [AW-1:0]     mem_req_addr,
  output logic [WORD_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_rdata,
  output logic              busy,
  output logic              done,
  output logic              err
);
  logic [AW-1:0]     pri_src, alt_src, alt_dst;
  logic [WORD_W-1:0] pri_ctrl, alt_ctrl, ld_data, pc_data;
  logic              ld_we, pc_we;
  logic [1:0]        ld_idx;

  sg_desc_store #(.AW(AW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_we    (cfg_we),
    .sw_sel   (cfg_sel),
    .sw_wdata (cfg_wdata),
    .ld_we    (ld_we),
    .ld_idx   (ld_idx),
    .ld_data  (ld_data),
    .pc_we    (pc_we),
    .pc_data  (pc_data),
    .pri_src  (pri_src),
    .pri_ctrl (pri_ctrl),
    .alt_src  (alt_src),
    .alt_dst  (alt_dst),
    .alt_ctrl (alt_ctrl)
  );

  sg_seq #(.AW(AW)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .cfg_we        (cfg_we),
    .pri_src       (pri_src),
    .pri_ctrl      (pri_ctrl),
    .alt_src       (alt_src),
    .alt_dst       (alt_dst),
    .alt_ctrl      (alt_ctrl),
    .ld_we         (ld_we),
    .ld_idx        (ld_idx),
    .ld_data       (ld_data),
    .pc_we         (pc_we),
    .pc_data       (pc_data),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_rdata (mem_rsp_rdata),
    .busy          (busy),
    .done          (done),
    .err           (err)
  );
endmodule

// File: rtl/sg_chain_dma_chk.sv
module sg_chain_dma_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_we,
  input logic [AW-1:0] mem_req_addr,
  input logic [31:0]   mem_req_wdata,
  input logic          mem_rsp_valid,
  input logic          busy,
  input logic          done,
  input logic          err
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata)); // R10
  AST_NO_REQ_ON_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> !mem_req_valid); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R6
  AST_ERR_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !done); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err && !cfg_we |=> err); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid); // R2
endmodule

bind sg_chain_dma sg_chain_dma_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_we        (cfg_we),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_we    (mem_req_we),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .mem_rsp_valid (mem_rsp_valid),
  .busy          (busy),
  .done          (done),
  .err           (err)
);

// File: tb/tb_sg_chain_dma.sv
module tb_sg_chain_dma;
  localparam int CLK_NS = 10;
  localparam int AW = 16;
  localparam int NVEC = 5;
  // [1:0] task count, [3:2] ending kind, [5:4] stall, [11:8] base length
  localparam logic [15:0] VEC [NVEC] = '{16'h0101, 16'h0313, 16'h0526,
                                         16'h023B, 16'h0832};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cfg_we = 1'b0;
  logic cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic mem_req_valid, mem_req_we, mem_req_ready;
  logic [AW-1:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;
  logic busy, done, err;

  logic [31:0] mem [1024];
  logic bd_we = 1'b0;
  logic [9:0] bd_addr = '0;
  logic [31:0] bd_data = '0;
  int stall = 0;
  int cyc = 0, rd_cnt = 0, wr_cnt = 0, done_cnt = 0;
  int n_chk = 0, n_fail = 0;

  always #(CLK_NS/2) clk = ~clk;

  sg_chain_dma #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .busy(busy), .done(done), .err(err)
  );

  assign mem_req_ready = (stall == 0) || (cyc % (stall + 1) == 0);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid <= 1'b0;
    if (done) done_cnt <= done_cnt + 1;
    if (bd_we) mem[bd_addr] <= bd_data;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        mem[mem_req_addr[9:0]] <= mem_req_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rsp_rdata <= mem[mem_req_addr[9:0]];
        mem_rsp_valid <= 1'b1;
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bd_write(input int a, input logic [31:0] d);
    @(negedge clk);
    bd_we = 1'b1; bd_addr = 10'(a); bd_data = d;
    @(negedge clk);
    bd_we = 1'b0;
  endtask

  task automatic cfg_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  logic done_at_end;
  task automatic run_chain();
    int guard;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (busy && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 20000) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog: chain did not end, actual=busy expected=idle");
    end
    done_at_end = done;
    @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] pat(input int v, input int t, input int i);
    return {8'(8'hA0 + v), 8'(t), 16'(i * 41 + 7)};
  endfunction

  function automatic logic [31:0] pri_ctrl_word(input int words, input logic [3:0] arb,
                                                input logic [2:0] code);
    return (32'(arb) << 14) | (32'(words - 1) << 4) | 32'(code);
  endfunction

  initial begin
    #(CLK_NS * 150000);
    $display("FAIL global watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_fail + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 err", 32'(err), 0);
    chk("R1 req_valid", 32'(mem_req_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      int nt, kind, base, sum, rd0, wr0, dn0;
      nt = int'(VEC[v][1:0]);
      kind = int'(VEC[v][3:2]);
      stall = int'(VEC[v][5:4]);
      base = int'(VEC[v][11:8]);
      sum = 0;
      for (int t = 0; t < nt; t++) begin
        int len;
        logic [2:0] code;
        len = base + t;
        if (t < nt - 1) code = 3'b101;
        else code = (kind == 0) ? 3'b001 : (kind == 1) ? 3'b101 : 3'b000;
        if (!(t == nt - 1 && kind == 2)) sum += len;
        for (int i = 0; i < len; i++) bd_write('h200 + t*'h40 + i, pat(v, t, i));
        for (int i = 0; i <= len; i++) bd_write('h300 + t*'h40 + i, 32'h0);
        bd_write('h100 + 4*t,     32'('h200 + t*'h40 + len - 1));
        bd_write('h100 + 4*t + 1, 32'('h300 + t*'h40 + len - 1));
        bd_write('h100 + 4*t + 2, (32'(len - 1) << 4) | 32'(code));
        bd_write('h100 + 4*t + 3, 32'hDEAD_BEEF);
      end
      // R11: program the primary through the configuration port
      cfg_write(1'b0, 32'('h100 + 4*nt - 1));
      cfg_write(1'b1, pri_ctrl_word(4*nt, 4'b0010, 3'b100));
      rd0 = rd_cnt; wr0 = wr_cnt; dn0 = done_cnt;
      run_chain();
      chk("R6 done at end", 32'(done_at_end), (kind == 0) ? 1 : 0);
      chk("R6 done count", 32'(done_cnt - dn0), (kind == 0) ? 1 : 0);
      chk("R7 err", 32'(err), (kind == 0) ? 0 : 1);
      chk("R3 read count", 32'(rd_cnt - rd0), 32'(4*nt + sum));
      chk("R5 write count", 32'(wr_cnt - wr0), 32'(sum));
      for (int t = 0; t < nt; t++) begin
        int len;
        len = base + t;
        for (int i = 0; i < len; i++)
          chk((t == nt - 1 && kind == 2) ? "R7 rejected task untouched" : "R5 copied data",
              mem['h300 + t*'h40 + i],
              (t == nt - 1 && kind == 2) ? 32'h0 : pat(v, t, i));
        chk("R4 no write past end", mem['h300 + t*'h40 + len], 32'h0);
      end
      if (kind == 1) begin
        repeat (3) @(negedge clk);
        chk("R9 err sticky", 32'(err), 1);
        cfg_write(1'b0, 32'('h100 + 4*nt - 1));
        chk("R9 err cleared by cfg write", 32'(err), 0);
        rd0 = rd_cnt;
        run_chain();
        chk("R8 restart after exhaustion errs", 32'(err), 1);
        chk("R8 restart issues no request", 32'(rd_cnt - rd0), 0);
      end
    end

    // R7: arbitration field other than 4'b0010
    stall = 0;
    cfg_write(1'b0, 32'h103);
    cfg_write(1'b1, pri_ctrl_word(4, 4'b0011, 3'b100));
    chk("R9 cfg write clears err", 32'(err), 0);
    begin
      int rd0, dn0;
      rd0 = rd_cnt; dn0 = done_cnt;
      run_chain();
      chk("R7 bad arb err", 32'(err), 1);
      chk("R7 bad arb no request", 32'(rd_cnt - rd0), 0);
      chk("R7 bad arb no done", 32'(done_cnt - dn0), 0);
      // R7: primary coded as basic instead of loader
      cfg_write(1'b1, pri_ctrl_word(4, 4'b0010, 3'b001));
      rd0 = rd_cnt;
      run_chain();
      chk("R7 bad primary code err", 32'(err), 1);
      chk("R7 bad primary code no request", 32'(rd_cnt - rd0), 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule